// File: doc/BRIEF.md
# Compare Timer with Pulse Counting

This block is a small memory-mapped timer. A 16-bit counter advances on one of two kinds of tick. In time mode the tick is the system clock, either taken directly or divided by a power of two. In pulse mode the tick is an asserted edge of one of four external inputs. A pulse-mode input can be inverted, and it can be cleaned by a glitch filter that needs a run of stable samples. The same 4-bit scale field sets the divider in time mode and the filter length in pulse mode.

When a tick arrives while the counter holds the compare value, a sticky match flag is raised. Depending on a control bit, the counter then either goes back to zero or keeps counting until it wraps. The flag can drive an interrupt line, a DMA request line, or both. Software clears the flag by writing a one to its bit. Software reads the counter by first writing any value to the counter register, which freezes a snapshot of the count. The mode, free-run and configuration fields can only be changed while the timer is stopped.

The register bus has no wait states. A write takes effect at the clock edge on which `reg_wr` is high. Read data is a combinational function of `reg_addr`, decoded from address bits [3:2].

Top module: `lpcmp_timer`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0, the configuration word (offset 0x4) reads 0x10 (bypass set, all else 0), compare (0x8) and snapshot (0xC) read 0, and `irq_o` and `dma_req_o` are low.
- R2: In time mode with bypass (config bit 4 = 1), the counter advances once per clock. With compare value C, the match flag (control bit 7) rises exactly C+1 clocks after the enabling write.
- R3: In time mode without bypass, scale value v (config bits [3:0]) makes one count take 2^(v+1) clocks. The flag therefore rises (C+1)*2^(v+1) clocks after enabling.
- R4: With free-run (control bit 2) clear, the counter returns to 0 on the tick that raises the flag.
- R5: With free-run set, the counter counts past the compare value, still raises the flag on the match, and wraps from 0xFFFF to 0.
- R6: In pulse mode (control bit 1 = 1) with bypass, each asserted edge of the input chosen by config bits [6:5] adds one. The other inputs have no effect.
- R7: With polarity (config bit 7) set, the chosen input is active-low, so its falling edges are counted.
- R8: In pulse mode without bypass, a level change is accepted only after 2^v consecutive samples at the new level. Shorter pulses are not counted.
- R9: The flag is sticky. Writing 1 to control bit 7 clears it and writing 0 leaves it unchanged. A match on the same edge as a clearing write leaves the flag set.
- R10: `irq_o` is the flag AND interrupt enable (control bit 3). `dma_req_o` is the flag AND DMA enable (control bit 4). Both drop when the flag is cleared.
- R11: A write of any value to offset 0xC captures the count present at that clock edge, before that edge's tick. Reads of 0xC return the captured value until the next such write.
- R12: Clearing run (control bit 0) forces the counter to 0, and setting it again starts counting from 0.
- R13: While run is set, writes to the mode and free-run bits and to the configuration word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pulse_in | input | 4 | External pulse inputs |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
Two pairs of events can fall on the same clock edge. In the first pair, a compare match coincides with a software write that clears the flag. The bench provokes this by timing the clearing write to the exact edge where the match is expected, and it judges the result by the flag still reading one afterwards. In the second pair, a snapshot write lands on an edge where the counter also ticks. Every snapshot is taken at a counted cycle, and the bench judges it against the pre-tick count derived from the number of edges since enabling.

// File: rtl/lpcmp_pkg.sv
`timescale 1ns/1ps
package lpcmp_pkg;

  typedef enum logic {
    MODE_TIME  = 1'b0,
    MODE_PULSE = 1'b1
  } lpcmp_mode_e;

  // register slots, decoded from address bits [3:2]
  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_CFG  = 2'd1;
  localparam logic [1:0] SLOT_CMP  = 2'd2;
  localparam logic [1:0] SLOT_SNAP = 2'd3;

  // control word bit positions
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_FREE = 2;
  localparam int CTRL_IRQ  = 3;
  localparam int CTRL_DMA  = 4;
  localparam int CTRL_FLAG = 7;

  // configuration word bit positions
  localparam int CFG_SCALE_LSB = 0;
  localparam int CFG_BYPASS    = 4;
  localparam int CFG_SEL_LSB   = 5;
  localparam int CFG_POL       = 7;

endpackage

// File: rtl/lpcmp_tick_gen.sv
`timescale 1ns/1ps
module lpcmp_tick_gen
  import lpcmp_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int NUM_IN  = 4,
  parameter int SEL_W   = $clog2(NUM_IN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  lpcmp_mode_e        mode,
  input  logic               bypass,
  input  logic [SCALE_W-1:0] scale,
  input  logic [SEL_W-1:0]   sel,
  input  logic               polarity,
  input  logic [NUM_IN-1:0]  pulse_in,
  output logic               tick
);

  localparam int DIV_W = 1 << SCALE_W;

  logic [NUM_IN-1:0] s1_q, s2_q;
  logic [DIV_W-1:0]  pre_q, pre_d, pre_mask;
  logic [DIV_W-1:0]  fcnt_q, fcnt_d, flt_lim;
  logic              flt_q, flt_d;
  logic              prev_q, prev_d;
  logic              act, lvl, time_tick, pulse_tick;

  // two-flop synchronizer per external input
  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[gi] <= 1'b0;
        s2_q[gi] <= 1'b0;
      end else begin
        s1_q[gi] <= pulse_in[gi];
        s2_q[gi] <= s1_q[gi];
      end
    end
  end

  always_comb begin
    pre_mask  = DIV_W'((32'd1 << (32'(scale) + 32'd1)) - 32'd1);
    flt_lim   = DIV_W'((32'd1 << 32'(scale)) - 32'd1);
    act       = s2_q[sel] ^ polarity;

    // prescaler: free counter, tick when the low v+1 bits are all ones
    time_tick = bypass | ((pre_q & pre_mask) == pre_mask);
    if (run_en && (mode == MODE_TIME) && !bypass) pre_d = pre_q + 1'b1;
    else                                          pre_d = '0;

    // glitch filter: level must differ for 2^v consecutive samples
    flt_d  = flt_q;
    fcnt_d = fcnt_q;
    if (!run_en) begin
      flt_d  = act;
      fcnt_d = '0;
    end else if (act == flt_q) begin
      fcnt_d = '0;
    end else if (fcnt_q == flt_lim) begin
      flt_d  = act;
      fcnt_d = '0;
    end else begin
      fcnt_d = fcnt_q + 1'b1;
    end

    lvl        = bypass ? act : flt_q;
    prev_d     = lvl;
    pulse_tick = lvl & ~prev_q;

    tick = run_en & ((mode == MODE_PULSE) ? pulse_tick : time_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      fcnt_q <= '0;
      flt_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      fcnt_q <= fcnt_d;
      flt_q  <= flt_d;
      prev_q <= prev_d;
    end
  end

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (mode == MODE_TIME) && !bypass && tick) |=> !tick); // R3

  AST_FILTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && $past(fcnt_q) != '0 && fcnt_q != '0)
      |-> (flt_q == $past(flt_q))); // R8

endmodule

// File: rtl/lpcmp_counter.sv
`timescale 1ns/1ps
module lpcmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             free_run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             flag_clr,
  input  logic             snap_req,
  output logic [CNT_W-1:0] snap_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, snap_q;
  logic             flag_q, flag_d, hit;

  always_comb begin
    hit = tick && (cnt_q == cmp_val);
    if (!run_en)               cnt_d = '0;
    else if (hit && !free_run) cnt_d = '0;
    else if (tick)             cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;

    // a match on the same edge as a clear keeps the flag
    if (hit)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      snap_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      if (snap_req) snap_q <= cnt_q;
    end
  end

  assign snap_o = snap_q;
  assign flag_o = flag_q;

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R2

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && run_en && !free_run) |=> (cnt_q == '0)); // R4

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_en && free_run) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R9

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_q == $past(cnt_q))); // R11

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/lpcmp_timer.sv
`timescale 1ns/1ps
module lpcmp_timer
  import lpcmp_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int SCALE_W = 4,
  parameter int NUM_IN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_IN-1:0] pulse_in,
  output logic              irq_o,
  output logic              dma_req_o
);

  localparam int SEL_W = $clog2(NUM_IN);

  logic rst_meta_q, rst_sync_q, rst_n_int;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_n_int = rst_sync_q;

  logic               run_q, run_d, free_q, free_d;
  logic               irq_en_q, irq_en_d, dma_en_q, dma_en_d;
  lpcmp_mode_e        mode_q, mode_d;
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic               bypass_q, bypass_d, pol_q, pol_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [CNT_W-1:0]   cmp_q, cmp_d, snap;
  logic               wr_ctrl, wr_cfg, wr_cmp, wr_snap, flag_clr, flag, tick;
  logic [1:0]         slot;

  always_comb begin
    slot     = reg_addr[3:2];
    wr_ctrl  = reg_wr && (slot == SLOT_CTRL);
    wr_cfg   = reg_wr && (slot == SLOT_CFG);
    wr_cmp   = reg_wr && (slot == SLOT_CMP);
    wr_snap  = reg_wr && (slot == SLOT_SNAP);
    flag_clr = wr_ctrl && reg_wdata[CTRL_FLAG];

    run_d    = run_q;
    mode_d   = mode_q;
    free_d   = free_q;
    irq_en_d = irq_en_q;
    dma_en_d = dma_en_q;
    scale_d  = scale_q;
    bypass_d = bypass_q;
    sel_d    = sel_q;
    pol_d    = pol_q;
    cmp_d    = cmp_q;

    if (wr_ctrl) begin
      run_d    = reg_wdata[CTRL_RUN];
      irq_en_d = reg_wdata[CTRL_IRQ];
      dma_en_d = reg_wdata[CTRL_DMA];
      if (!run_q) begin
        mode_d = lpcmp_mode_e'(reg_wdata[CTRL_MODE]);
        free_d = reg_wdata[CTRL_FREE];
      end
    end
    if (wr_cfg && !run_q) begin
      scale_d  = reg_wdata[CFG_SCALE_LSB +: SCALE_W];
      bypass_d = reg_wdata[CFG_BYPASS];
      sel_d    = reg_wdata[CFG_SEL_LSB +: SEL_W];
      pol_d    = reg_wdata[CFG_POL];
    end
    if (wr_cmp) cmp_d = reg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      run_q    <= 1'b0;
      mode_q   <= MODE_TIME;
      free_q   <= 1'b0;
      irq_en_q <= 1'b0;
      dma_en_q <= 1'b0;
      scale_q  <= '0;
      bypass_q <= 1'b1;
      sel_q    <= '0;
      pol_q    <= 1'b0;
      cmp_q    <= '0;
    end else begin
      run_q    <= run_d;
      mode_q   <= mode_d;
      free_q   <= free_d;
      irq_en_q <= irq_en_d;
      dma_en_q <= dma_en_d;
      scale_q  <= scale_d;
      bypass_q <= bypass_d;
      sel_q    <= sel_d;
      pol_q    <= pol_d;
      cmp_q    <= cmp_d;
    end
  end

  lpcmp_tick_gen #(
    .SCALE_W (SCALE_W),
    .NUM_IN  (NUM_IN),
    .SEL_W   (SEL_W)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run_en   (run_q),
    .mode     (mode_q),
    .bypass   (bypass_q),
    .scale    (scale_q),
    .sel      (sel_q),
    .polarity (pol_q),
    .pulse_in (pulse_in),
    .tick     (tick)
  );

  lpcmp_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run_en   (run_q),
    .free_run (free_q),
    .tick     (tick),
    .cmp_val  (cmp_q),
    .flag_clr (flag_clr),
    .snap_req (wr_snap),
    .snap_o   (snap),
    .flag_o   (flag)
  );

  assign irq_o     = flag & irq_en_q;
  assign dma_req_o = flag & dma_en_q;

  always_comb begin
    reg_rdata = '0;
    case (slot)
      SLOT_CTRL: begin
        reg_rdata[CTRL_RUN]  = run_q;
        reg_rdata[CTRL_MODE] = mode_q;
        reg_rdata[CTRL_FREE] = free_q;
        reg_rdata[CTRL_IRQ]  = irq_en_q;
        reg_rdata[CTRL_DMA]  = dma_en_q;
        reg_rdata[CTRL_FLAG] = flag;
      end
      SLOT_CFG: begin
        reg_rdata[CFG_SCALE_LSB +: SCALE_W] = scale_q;
        reg_rdata[CFG_BYPASS]               = bypass_q;
        reg_rdata[CFG_SEL_LSB +: SEL_W]     = sel_q;
        reg_rdata[CFG_POL]                  = pol_q;
      end
      SLOT_CMP: reg_rdata[CNT_W-1:0] = cmp_q;
      default:  reg_rdata[CNT_W-1:0] = snap;
    endcase
  end

  logic unused_bus;
  assign unused_bus = ^{reg_addr[1:0], reg_wdata[DATA_W-1:CNT_W]};

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n_int)
    run_q |=> $stable({mode_q, free_q, scale_q, bypass_q, sel_q, pol_q})); // R13

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(flag) |-> (!irq_o && !dma_req_o)); // R10

endmodule

// File: tb/lpcmp_timer_tb.sv
`timescale 1ns/1ps
module lpcmp_timer_tb_top;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_CFG  = 4'h4;
  localparam logic [3:0] A_CMP  = 4'h8;
  localparam logic [3:0] A_SNAP = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pulse_in;
  logic        irq_o, dma_req_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lpcmp_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pulse_in  (pulse_in),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_flag(output logic f);
    logic [31:0] v;
    rd(A_CTRL, v);
    f = v[7];
  endtask

  task automatic snap_read(output logic [31:0] d);
    wr(A_SNAP, 32'h0);
    rd(A_SNAP, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_CFG, v);  chk("R1 cfg", v, 32'h10);
    rd(A_CMP, v);  chk("R1 cmp", v, 32'h0);
    rd(A_SNAP, v); chk("R1 snap", v, 32'h0);
    chk("R1 irq/dma", {30'b0, irq_o, dma_req_o}, 32'h0);
  endtask

  task automatic t_time_bypass;
    logic [31:0] v;
    logic f;
    wr(A_CMP, 32'd20);
    wr(A_CTRL, 32'h1);                         // enable edge P0
    idle(9);
    snap_read(v); chk("R11 snapshot at P10", v, 32'd9);
    idle(2);
    rd(A_SNAP, v); chk("R11 snapshot held", v, 32'd9);
    idle(8);                                   // through P20
    rd_flag(f); chk("R2 flag before C+1", {31'b0, f}, 32'd0);
    idle(1);                                   // P21
    rd_flag(f); chk("R2 flag at C+1", {31'b0, f}, 32'd1);
    snap_read(v); chk("R4 counter back to zero", v, 32'd0);
    wr(A_CTRL, 32'h0);
    rd_flag(f); chk("R9 write 0 keeps flag", {31'b0, f}, 32'd1);
    wr(A_CTRL, 32'h80);
    rd_flag(f); chk("R9 write 1 clears flag", {31'b0, f}, 32'd0);
    snap_read(v); chk("R12 stopped counter is zero", v, 32'd0);
  endtask

  task automatic t_prescale;
    logic f;
    wr(A_CFG, 32'h01);                         // v=1, divide by 4
    wr(A_CMP, 32'd2);
    wr(A_CTRL, 32'h1);
    idle(11);
    rd_flag(f); chk("R3 div4 flag early", {31'b0, f}, 32'd0);
    idle(1);
    rd_flag(f); chk("R3 div4 flag at 12", {31'b0, f}, 32'd1);
    wr(A_CTRL, 32'h80);
    wr(A_CFG, 32'h00);                         // v=0, divide by 2
    wr(A_CMP, 32'd1);
    wr(A_CTRL, 32'h1);
    idle(3);
    rd_flag(f); chk("R3 div2 flag early", {31'b0, f}, 32'd0);
    idle(1);
    rd_flag(f); chk("R3 div2 flag at 4", {31'b0, f}, 32'd1);
    wr(A_CTRL, 32'h80);
    wr(A_CFG, 32'h10);
  endtask

  task automatic t_free_run;
    logic [31:0] v;
    logic f;
    wr(A_CMP, 32'd3);
    wr(A_CTRL, 32'h5);
    idle(9);
    snap_read(v); chk("R5 counts past compare", v, 32'd9);
    rd_flag(f); chk("R5 flag on match", {31'b0, f}, 32'd1);
    wr(A_CTRL, 32'h80);
    wr(A_CMP, 32'd10);
    wr(A_CTRL, 32'h5);
    idle(65537);
    snap_read(v); chk("R5 wrap at 16 bits", v, 32'd1);
    wr(A_CTRL, 32'h80);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(A_CMP, 32'd100);
    wr(A_CTRL, 32'h1);
    idle(4);
    snap_read(v); chk("R12 first run", v, 32'd4);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    idle(2);
    snap_read(v); chk("R12 restart from zero", v, 32'd2);
    wr(A_CTRL, 32'h80);
  endtask

  task automatic t_flag_irq;
    logic f;
    wr(A_CMP, 32'd3);
    wr(A_CTRL, 32'h19);                        // run, irq and dma enabled
    idle(3);
    wr(A_CTRL, 32'h99);                        // clear on the match edge P4
    rd_flag(f); chk("R9 match beats clear", {31'b0, f}, 32'd1);
    chk("R10 irq and dma", {30'b0, irq_o, dma_req_o}, 32'd3);
    wr(A_CTRL, 32'h09);
    chk("R10 dma disabled", {30'b0, irq_o, dma_req_o}, 32'd2);
    wr(A_CTRL, 32'h99);
    rd_flag(f); chk("R9 clear", {31'b0, f}, 32'd0);
    chk("R10 both drop", {30'b0, irq_o, dma_req_o}, 32'd0);
    wr(A_CTRL, 32'h80);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(A_CMP, 32'd1000);
    wr(A_CTRL, 32'h1);
    wr(A_CFG, 32'h0F);
    wr(A_CTRL, 32'h7);
    rd(A_CTRL, v); chk("R13 mode/free locked", v, 32'h1);
    wr(A_CTRL, 32'h0);
    rd(A_CFG, v); chk("R13 cfg locked", v, 32'h10);
  endtask

  task automatic t_pulse;
    logic [31:0] v;
    pulse_in = 4'h0;
    wr(A_CFG, 32'h50);                         // bypass, input 2
    idle(4);
    wr(A_CTRL, 32'h3);
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 8; c++) begin
        pulse_in[2] = (c < 4);
        pulse_in[1] = c[0];
        @(negedge clk);
      end
    end
    idle(6);
    snap_read(v); chk("R6 selected input edges", v, 32'd3);
    wr(A_CTRL, 32'h0);
    pulse_in = 4'h4;                           // idle high for active-low
    wr(A_CFG, 32'hD0);
    idle(4);
    wr(A_CTRL, 32'h3);
    for (int p = 0; p < 3; p++) begin
      pulse_in[2] = 1'b0; idle(4);
      pulse_in[2] = 1'b1; idle(4);
    end
    idle(6);
    snap_read(v); chk("R7 active-low edges", v, 32'd3);
    wr(A_CTRL, 32'h80);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    pulse_in = 4'h0;
    wr(A_CFG, 32'h02);                         // filter 4 samples, input 0
    idle(4);
    wr(A_CTRL, 32'h3);
    pulse_in[0] = 1'b1; idle(2); pulse_in[0] = 1'b0; idle(8);
    pulse_in[0] = 1'b1; idle(3); pulse_in[0] = 1'b0; idle(8);
    snap_read(v); chk("R8 glitches rejected", v, 32'd0);
    pulse_in[0] = 1'b1; idle(8); pulse_in[0] = 1'b0; idle(8);
    snap_read(v); chk("R8 long pulse counted", v, 32'd1);
    wr(A_CTRL, 32'h80);
    wr(A_CFG, 32'h10);
  endtask

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = 4'h0;
    reg_wdata = 32'h0;
    pulse_in  = 4'h0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_time_bypass();
    t_prescale();
    t_free_run();
    t_restart();
    t_flag_irq();
    t_lock();
    t_pulse();
    t_filter();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule